// File: doc/BRIEF.md
# Audio Sample Write-Mode Packer

This block takes audio sample writes from a simple register-write bus and turns them into complete left/right sample-pair entries for a downstream pair-oriented sample queue. Software picks one of three write methods at run time. In two-address interleaved mode the left sample and then the right sample arrive as separate writes to two addresses. In packed mode one write carries both channels as two 16-bit halves. In mono mode each write carries one sample, which goes to both channels.

Samples of 16, 20, 24 or 32 bits are accepted right-aligned on the write data bus. They are stored left-aligned in the 32-bit channel fields of the queue entry, so the queue and the serializer after it always see the most significant bit at bit 31. The push strobe and the entry are produced combinationally in the cycle of the accepting write. When the queue reports full, a write that would be decoded is refused and a busy flag is raised in that same cycle.

Top module: `smp_pair_packer`

## Requirements
- R1: Mode 0 (`mode_sel`=0) is interleaved. A write to address `ADDR_LEFT` (default 0) stores the left sample and does not push. A write to `ADDR_RIGHT` (default 1) raises `q_push` in the same cycle, with `q_left` set to the held left sample and `q_right` set to the aligned right sample.
- R2: In mode 0, a second left write without a right write between them replaces the held left sample. The next push carries the newer value.
- R3: Mode 1 is packed. A write to `ADDR_LEFT` pushes `q_left`={wr_data[31:16],16'h0} and `q_right`={wr_data[15:0],16'h0}. `width_sel` has no effect in this mode.
- R4: Mode 2 is mono. A write to `ADDR_LEFT` pushes the aligned sample into both `q_left` and `q_right`.
- R5: `width_sel` encodes the sample width: 0=16, 1=20, 2=24, 3=32 bits. The sample is taken from the low bits of `wr_data`. Its top bit is placed at bit 31, the bits below it are zero, and data bits above the width are ignored.
- R6: A decoded write while `q_full` is high raises `wr_busy` in that cycle. It does not push and does not change the held left sample.
- R7: Writes that are not decoded have no effect: mode 3, `ADDR_RIGHT` in modes 1 and 2, and any other address. They give no push, no busy and no change to the held left sample, even when `q_full` is high.
- R8: Reset clears the held left sample to zero. Without a write, `q_push` and `wr_busy` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Write method: 0 interleaved, 1 packed, 2 mono, 3 none |
| width_sel | input | 2 | Sample width code: 0=16, 1=20, 2=24, 3=32 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data, samples right-aligned |
| wr_busy | output | 1 | Write refused because the queue is full |
| q_full | input | 1 | Queue cannot take an entry |
| q_push | output | 1 | Push one pair entry into the queue |
| q_left | output | 32 | Left channel field, left-aligned |
| q_right | output | 32 | Right channel field, left-aligned |

## Verification
The only state in the block is the held left sample. If it is corrupted, the ports show nothing until the next interleaved right write, and that push then carries a wrong `q_left`. The bench therefore follows every stimulus that must not touch the held sample with a right write. Decode or alignment errors show up in `q_push`, `wr_busy` or the entry fields in the same cycle as the write, so each write is checked in its own cycle before the clock edge.

// File: rtl/smp_pack_pkg.sv
package smp_pack_pkg;

   localparam int unsigned CH_W = 32;

   typedef enum logic [1:0] {
      MODE_ILV  = 2'd0,
      MODE_PACK = 2'd1,
      MODE_MONO = 2'd2,
      MODE_NONE = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      W16 = 2'd0,
      W20 = 2'd1,
      W24 = 2'd2,
      W32 = 2'd3
   } swidth_e;

   typedef struct packed {
      logic [CH_W-1:0] left;
      logic [CH_W-1:0] right;
   } pair_t;

endpackage

// File: rtl/smp_align.sv
module smp_align
   import smp_pack_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0] raw,
   input  swidth_e       wsel,
   output logic [DW-1:0] aligned
);
   if (DW != 32) begin : g_dw_check
      $error("smp_align: DW must be 32");
   end

   always_comb begin
      unique case (wsel)
         W16:     aligned = {raw[15:0], 16'h0000};
         W20:     aligned = {raw[19:0], 12'h000};
         W24:     aligned = {raw[23:0], 8'h00};
         default: aligned = raw;
      endcase
   end
endmodule

// File: rtl/smp_wr_decode.sv
module smp_wr_decode
   import smp_pack_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned ADDR_LEFT  = 0,
   parameter int unsigned ADDR_RIGHT = 1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  wmode_e            mode,
   input  logic              full,
   output logic              store_left,
   output logic              push,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] A_L = ADDR_W'(ADDR_LEFT);
   localparam logic [ADDR_W-1:0] A_R = ADDR_W'(ADDR_RIGHT);

   logic hit_l, hit_r, hit_w, hit_any;

   always_comb begin
      hit_l   = wr_en && (mode == MODE_ILV) && (wr_addr == A_L);
      hit_r   = wr_en && (mode == MODE_ILV) && (wr_addr == A_R);
      hit_w   = wr_en && ((mode == MODE_PACK) || (mode == MODE_MONO))
                && (wr_addr == A_L);
      hit_any = hit_l || hit_r || hit_w;
      busy       = hit_any && full;
      store_left = hit_l && !full;
      push       = (hit_r || hit_w) && !full;
   end
endmodule

// File: rtl/smp_left_hold.sv
module smp_left_hold #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/smp_pair_packer.sv
module smp_pair_packer
   import smp_pack_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned ADDR_LEFT  = 0,
   parameter int unsigned ADDR_RIGHT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic [1:0]        width_sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              wr_busy,
   input  logic              q_full,
   output logic              q_push,
   output logic [31:0]       q_left,
   output logic [31:0]       q_right
);
   localparam int unsigned HALF = CH_W / 2;

   if (ADDR_LEFT == ADDR_RIGHT) begin : g_addr_same
      $error("smp_pair_packer: ADDR_LEFT and ADDR_RIGHT must differ");
   end
   if ((ADDR_LEFT >> ADDR_W) != 0 || (ADDR_RIGHT >> ADDR_W) != 0) begin : g_addr_fit
      $error("smp_pair_packer: addresses do not fit ADDR_W");
   end

   wmode_e          mode;
   swidth_e         wsel;
   logic [CH_W-1:0] smp_al;
   logic [CH_W-1:0] held_l;
   logic            store_l;
   pair_t           entry;

   assign mode = wmode_e'(mode_sel);
   assign wsel = swidth_e'(width_sel);

   smp_align #(.DW(CH_W)) u_align (
      .raw     (wr_data),
      .wsel    (wsel),
      .aligned (smp_al)
   );

   smp_wr_decode #(
      .ADDR_W     (ADDR_W),
      .ADDR_LEFT  (ADDR_LEFT),
      .ADDR_RIGHT (ADDR_RIGHT)
   ) u_dec (
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .mode       (mode),
      .full       (q_full),
      .store_left (store_l),
      .push       (q_push),
      .busy       (wr_busy)
   );

   smp_left_hold #(.DW(CH_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (store_l),
      .d     (smp_al),
      .q     (held_l)
   );

   always_comb begin
      unique case (mode)
         MODE_ILV: begin
            entry.left  = held_l;
            entry.right = smp_al;
         end
         MODE_PACK: begin
            entry.left  = {wr_data[CH_W-1:HALF], {HALF{1'b0}}};
            entry.right = {wr_data[HALF-1:0],    {HALF{1'b0}}};
         end
         default: begin
            entry.left  = smp_al;
            entry.right = smp_al;
         end
      endcase
   end

   assign q_left  = entry.left;
   assign q_right = entry.right;
endmodule

// File: rtl/smp_pair_packer_chk.sv
module smp_pair_packer_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned ADDR_LEFT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_sel,
   input logic [1:0]        width_sel,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic              wr_busy,
   input logic              q_full,
   input logic              q_push,
   input logic [31:0]       q_left,
   input logic [31:0]       q_right
);
   a_r6_busy_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> !q_push);

   a_r6_busy_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> (q_full && wr_en));

   a_r8_push_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> (wr_en && !q_full));

   a_r7_mode3_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd3) |-> (!q_push && !wr_busy));

   a_r4_mono_dup: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && mode_sel == 2'd2) |-> (q_left == q_right));

   a_r5_low16_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && mode_sel == 2'd2 && width_sel == 2'd0) |-> (q_left[15:0] == 16'h0));

   a_r3_pack_split: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && mode_sel == 2'd1) |-> (q_left == {wr_data[31:16], 16'h0}));

   a_r1_left_carried: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && mode_sel == 2'd0
       && $past(rst_n && wr_en && !q_full && mode_sel == 2'd0 && width_sel == 2'd3
                && wr_addr == ADDR_W'(ADDR_LEFT)))
      |-> (q_left == $past(wr_data)));
endmodule

bind smp_pair_packer smp_pair_packer_chk #(
   .ADDR_W    (ADDR_W),
   .ADDR_LEFT (ADDR_LEFT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .width_sel (width_sel),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wr_busy   (wr_busy),
   .q_full    (q_full),
   .q_push    (q_push),
   .q_left    (q_left),
   .q_right   (q_right)
);

// File: tb/smp_pair_packer_bench.sv
module smp_pair_packer_bench;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_sel = 2'd0;
   logic [1:0]    width_sel = 2'd3;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          q_full = 1'b0;
   logic          wr_busy, q_push;
   logic [31:0]   q_left, q_right;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   smp_pair_packer #(.ADDR_W(AW), .ADDR_LEFT(0), .ADDR_RIGHT(1)) u_smp_pair_packer (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .width_sel(width_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy),
      .q_full(q_full), .q_push(q_push), .q_left(q_left), .q_right(q_right)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at falling edge, settle, caller checks before the rising edge
   task automatic wr(input logic [1:0] m, input logic [1:0] w, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic full);
      @(negedge clk);
      mode_sel = m; width_sel = w; wr_addr = a; wr_data = d; q_full = full; wr_en = 1'b1;
      #3;
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; q_full = 1'b0;
      #3;
   endtask

   task automatic expect_push(input string tag, input logic [31:0] l, input logic [31:0] r);
      chk(q_push === 1'b1, {tag, " push"}, {31'd0, q_push}, 32'd1);
      chk(wr_busy === 1'b0, {tag, " busy"}, {31'd0, wr_busy}, 32'd0);
      chk(q_left === l, {tag, " left"}, q_left, l);
      chk(q_right === r, {tag, " right"}, q_right, r);
   endtask

   task automatic expect_quiet(input string tag, input logic busy_exp);
      chk(q_push === 1'b0, {tag, " push"}, {31'd0, q_push}, 32'd0);
      chk(wr_busy === busy_exp, {tag, " busy"}, {31'd0, wr_busy}, {31'd0, busy_exp});
   endtask

   task automatic t_reset();
      #3;
      expect_quiet("R8 idle after reset", 1'b0);
      wr(2'd0, 2'd3, 4'd1, 32'hCAFE0001, 1'b0);
      expect_push("R8 reset held left zero", 32'h0, 32'hCAFE0001);
      idle();
   endtask

   task automatic t_interleave();
      wr(2'd0, 2'd3, 4'd0, 32'h11112222, 1'b0);
      expect_quiet("R1 left write no push", 1'b0);
      wr(2'd0, 2'd3, 4'd1, 32'h33334444, 1'b0);
      expect_push("R1 pair", 32'h11112222, 32'h33334444);
      wr(2'd0, 2'd0, 4'd0, 32'hFFFF8765, 1'b0);
      wr(2'd0, 2'd0, 4'd1, 32'h00004321, 1'b0);
      expect_push("R1 R5 16-bit pair", 32'h87650000, 32'h43210000);
      idle();
   endtask

   task automatic t_overwrite();
      wr(2'd0, 2'd3, 4'd0, 32'hAAAA0000, 1'b0);
      wr(2'd0, 2'd3, 4'd0, 32'hBBBB0000, 1'b0);
      expect_quiet("R2 second left no push", 1'b0);
      wr(2'd0, 2'd3, 4'd1, 32'hCCCC0000, 1'b0);
      expect_push("R2 newer left", 32'hBBBB0000, 32'hCCCC0000);
      idle();
   endtask

   task automatic t_packed();
      wr(2'd1, 2'd1, 4'd0, 32'hABCD1234, 1'b0);
      expect_push("R3 packed a", 32'hABCD0000, 32'h12340000);
      wr(2'd1, 2'd3, 4'd0, 32'h8001FFFF, 1'b0);
      expect_push("R3 packed b", 32'h80010000, 32'hFFFF0000);
      idle();
   endtask

   task automatic t_mono_widths();
      wr(2'd2, 2'd0, 4'd0, 32'hDEADBEEF, 1'b0);
      expect_push("R4 R5 w16", 32'hBEEF0000, 32'hBEEF0000);
      wr(2'd2, 2'd1, 4'd0, 32'hDEADBEEF, 1'b0);
      expect_push("R4 R5 w20", 32'hDBEEF000, 32'hDBEEF000);
      wr(2'd2, 2'd2, 4'd0, 32'hFF123456, 1'b0);
      expect_push("R4 R5 w24", 32'h12345600, 32'h12345600);
      wr(2'd2, 2'd3, 4'd0, 32'hDEADBEEF, 1'b0);
      expect_push("R4 R5 w32", 32'hDEADBEEF, 32'hDEADBEEF);
      idle();
   endtask

   task automatic t_busy();
      wr(2'd0, 2'd3, 4'd0, 32'h55550000, 1'b0);
      wr(2'd0, 2'd3, 4'd1, 32'h66660000, 1'b1);
      expect_quiet("R6 right when full", 1'b1);
      wr(2'd0, 2'd3, 4'd0, 32'h77770000, 1'b1);
      expect_quiet("R6 left when full", 1'b1);
      wr(2'd1, 2'd3, 4'd0, 32'h12345678, 1'b1);
      expect_quiet("R6 packed when full", 1'b1);
      wr(2'd0, 2'd3, 4'd1, 32'h88880000, 1'b0);
      expect_push("R6 held left kept", 32'h55550000, 32'h88880000);
      idle();
   endtask

   task automatic t_ignored();
      wr(2'd0, 2'd3, 4'd0, 32'h0A0A0A0A, 1'b0);
      wr(2'd3, 2'd3, 4'd0, 32'h11111111, 1'b1);
      expect_quiet("R7 mode3 full", 1'b0);
      wr(2'd3, 2'd3, 4'd1, 32'h22222222, 1'b0);
      expect_quiet("R7 mode3", 1'b0);
      wr(2'd1, 2'd3, 4'd1, 32'h33333333, 1'b0);
      expect_quiet("R7 packed addr1", 1'b0);
      wr(2'd2, 2'd3, 4'd1, 32'h44444444, 1'b1);
      expect_quiet("R7 mono addr1 full", 1'b0);
      wr(2'd0, 2'd3, 4'd5, 32'h55555555, 1'b0);
      expect_quiet("R7 interleaved addr5", 1'b0);
      wr(2'd0, 2'd3, 4'd1, 32'h0B0B0B0B, 1'b0);
      expect_push("R7 held left kept", 32'h0A0A0A0A, 32'h0B0B0B0B);
      idle();
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_interleave();
      t_overwrite();
      t_packed();
      t_mono_widths();
      t_busy();
      t_ignored();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule